// File: doc/BRIEF.md
# ADC Regular-Group Sequence Controller

This block walks the channel list of an ADC regular conversion group and hands one channel at a time to a converter through a start/done handshake. Software configures up to sixteen channel numbers, a sequence length, a discontinuous-mode enable and a subgroup size. All of these arrive on plain input ports. An external trigger starts the work, and the block reports each finished conversion and the end of the whole list.

With discontinuous mode off, one trigger converts the whole list in order. Every later trigger starts the list again from the first entry. With discontinuous mode on, a trigger converts only the next subgroup of channels. The block keeps its place between triggers. After the final subgroup, the next trigger starts again at the first entry.

The converter model is abstract. The block raises a one-cycle request together with a channel number. It waits for a one-cycle done before it asks for the next channel.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it, `conv_start`, `eoc`, `eos` and `busy` are low. The first trigger after reset converts entry 0 first.
- R2: With `disc_en` low, one trigger requests entries 0, 1, … up to the last entry in ascending order. Entry i is taken from bits [5i+4:5i] of `seq_chans`.
- R3: With `disc_en` low, every later trigger requests the whole list again, starting at entry 0.
- R4: With `disc_en` high, a trigger requests the next `disc_size`+1 entries (field value 0 means 1 channel, 7 means 8). The position is held between triggers.
- R5: With `disc_en` high, the trigger that follows the subgroup containing the last entry starts at entry 0.
- R6: If fewer entries than the subgroup size remain, the subgroup ends at the last entry and raises `eos` there.
- R7: `eoc` is a one-cycle pulse in the cycle after each accepted `conv_done`. There is exactly one pulse per conversion.
- R8: `eos` pulses together with the `eoc` of the last entry of the sequence and at no other time.
- R9: A trigger that arrives while `busy` is high is ignored.
- R10: Only one request is outstanding at a time. A `conv_done` that arrives when no request is pending is ignored and produces no `eoc`.
- R11: Lowering `enable` aborts any pending request, drops `busy` the next cycle, and returns the position to entry 0.
- R12: `seq_len` encodes the list length as field value plus one. The value 15 gives 16 entries, and the value 0 gives 1 entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and rewinds |
| trigger | input | 1 | External start event, sampled per cycle |
| disc_en | input | 1 | Discontinuous (subgroup) mode enable |
| disc_size | input | 3 | Subgroup size minus one |
| seq_len | input | 4 | Sequence length minus one |
| seq_chans | input | 80 | Sixteen 5-bit channel numbers, entry 0 in the low bits |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 5 | Channel number for the request |
| conv_done | input | 1 | Converter finished the pending request |
| eoc | output | 1 | End-of-conversion pulse |
| eos | output | 1 | End-of-sequence pulse |
| busy | output | 1 | A subgroup or sequence is in progress |

## Verification
Two events can land in the same cycle: the close of a subgroup and the close of the whole sequence. Both happen when the last entry finishes and the subgroup boundary falls on that entry or would fall beyond it. The tests provoke this with a nine-entry list split in threes, where the boundaries line up exactly. They also use a ten-entry list split in fours, where the last subgroup is cut short. In each case the bench records at which `eoc` the `eos` pulse came. It then checks that the next trigger starts again at entry 0 rather than continuing past the end.

// File: rtl/adc_seq_pkg.sv
// Package: shared sizes and the handshake state type for the sequence controller.
// Assumes channel numbers of 5 bits and a list of at most 16 entries.
package adc_seq_pkg;
    parameter int CHAN_W   = 5;
    parameter int MAX_LEN  = 16;
    parameter int GRP_W    = 3;
    localparam int IDX_W   = $clog2(MAX_LEN);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_seq_chsel.sv
// Module: unpacks the flat channel list and selects the entry at the pointer.
// Assumes entry i sits at bits [CHAN_W*i +: CHAN_W] of the flat vector.
module adc_seq_chsel #(
    parameter int CHAN_W  = 5,
    parameter int MAX_LEN = 16,
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic [CHAN_W*MAX_LEN-1:0] chans_flat,
    input  logic [IDX_W-1:0]          sel,
    output logic [CHAN_W-1:0]         chan
);
    logic [CHAN_W-1:0] entry [MAX_LEN];

    // Split the flat vector into one slot per entry.
    for (genvar g = 0; g < MAX_LEN; g++) begin : g_unpack
        assign entry[g] = chans_flat[CHAN_W*g +: CHAN_W];
    end

    // Pick the entry addressed by the pointer.
    always_comb begin
        chan = entry[sel];
    end
endmodule

// File: rtl/adc_seq_ptr.sv
// Module: holds the sequence position and the count within the current subgroup.
// Assumes 'advance' is raised once per finished conversion and 'open_grp' once per accepted trigger.
module adc_seq_ptr #(
    parameter int MAX_LEN = 16,
    parameter int GRP_W   = 3,
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rewind,
    input  logic             open_grp,
    input  logic             advance,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             disc_en,
    input  logic [GRP_W-1:0] grp_last,
    output logic [IDX_W-1:0] ptr,
    output logic             at_last,
    output logic             stop
);
    logic [GRP_W-1:0] sub_cnt;
    logic             grp_full;

    // Decode end of list and end of subgroup for the entry now converting.
    always_comb begin
        at_last  = (ptr >= last_idx);
        grp_full = disc_en && (sub_cnt == grp_last);
        stop     = at_last || grp_full;
    end

    // Move the position forward after each conversion; wrap at the list end.
    always_ff @(posedge clk) begin
        if (!rst_n || rewind) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= at_last ? '0 : ptr + 1'b1;
        end
    end

    // Count conversions inside the subgroup opened by the latest trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || rewind) begin
            sub_cnt <= '0;
        end else if (open_grp) begin
            sub_cnt <= '0;
        end else if (advance) begin
            sub_cnt <= sub_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// Module: request/done handshake sequencer; one request outstanding at a time.
// Assumes conv_done is a one-cycle pulse; done outside the wait state is dropped.
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trigger,
    input  logic conv_done,
    input  logic stop,
    output logic open_grp,
    output logic advance,
    output logic req,
    output logic busy
);
    seq_state_t state, state_nx;

    // Decide the next state and the single-cycle strobes.
    always_comb begin
        state_nx = state;
        open_grp = 1'b0;
        advance  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (trigger) begin
                    open_grp = 1'b1;
                    state_nx = ST_ISSUE;
                end
            end
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT: begin
                if (conv_done) begin
                    advance  = 1'b1;
                    state_nx = stop ? ST_IDLE : ST_ISSUE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        if (!enable) begin
            open_grp = 1'b0;
            advance  = 1'b0;
            state_nx = ST_IDLE;
        end
    end

    // Hold the handshake state; reset forces idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Drive the request strobe and the activity flag from the state.
    always_comb begin
        req  = (state == ST_ISSUE);
        busy = (state != ST_IDLE);
    end
endmodule

// File: rtl/adc_seq_evt.sv
// Module: registers the end-of-conversion and end-of-sequence pulses.
// Assumes 'advance' marks a finished conversion and 'at_last' the final entry.
module adc_seq_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic at_last,
    output logic eoc,
    output logic eos
);
    // One pulse per finished conversion; end-of-sequence rides on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc <= 1'b0;
            eos <= 1'b0;
        end else begin
            eoc <= advance;
            eos <= advance && at_last;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: top of the regular-group sequence controller.
// Walks a programmed channel list, in full or in subgroups, over a start/done port.
// Assumes configuration inputs are held steady while busy is high.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = adc_seq_pkg::CHAN_W,
    parameter int LEN    = adc_seq_pkg::MAX_LEN,
    parameter int GW     = adc_seq_pkg::GRP_W,
    localparam int PW    = $clog2(LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trigger,
    input  logic             disc_en,
    input  logic [GW-1:0]    disc_size,
    input  logic [PW-1:0]    seq_len,
    input  logic [CH_W*LEN-1:0] seq_chans,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    output logic             eoc,
    output logic             eos,
    output logic             busy
);
    logic          open_grp;
    logic          advance;
    logic          stop;
    logic          at_last;
    logic [PW-1:0] ptr;

    adc_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .trigger   (trigger),
        .conv_done (conv_done),
        .stop      (stop),
        .open_grp  (open_grp),
        .advance   (advance),
        .req       (conv_start),
        .busy      (busy)
    );

    adc_seq_ptr #(.MAX_LEN(LEN), .GRP_W(GW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rewind   (!enable),
        .open_grp (open_grp),
        .advance  (advance),
        .last_idx (seq_len),
        .disc_en  (disc_en),
        .grp_last (disc_size),
        .ptr      (ptr),
        .at_last  (at_last),
        .stop     (stop)
    );

    adc_seq_chsel #(.CHAN_W(CH_W), .MAX_LEN(LEN)) u_sel (
        .chans_flat (seq_chans),
        .sel        (ptr),
        .chan       (conv_chan)
    );

    adc_seq_evt u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .at_last (at_last),
        .eoc     (eoc),
        .eos     (eos)
    );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Module: protocol checker bound to the sequence controller top.
// Assumes it sees only top-level ports.
module adc_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic conv_start,
    input logic conv_done,
    input logic eoc,
    input logic eos,
    input logic busy
);
    logic pending;

    // Track whether a request has been issued and not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)  pending <= 1'b0;
        else if (conv_start)    pending <= 1'b1;
        else if (conv_done)     pending <= 1'b0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!conv_start && !eoc && !eos && !busy));

    a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !pending);

    a_r7_eoc_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> $past(conv_done));

    a_r7_eoc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> !eoc);

    a_r8_eos_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> eoc);

    a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !conv_start));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .eoc        (eoc),
    .eos        (eos),
    .busy       (busy)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        trigger = 1'b0;
    logic        disc_en = 1'b0;
    logic [2:0]  disc_size = 3'd0;
    logic [3:0]  seq_len = 4'd0;
    logic [79:0] seq_chans = '0;
    logic        conv_start;
    logic [4:0]  conv_chan;
    logic        conv_done;
    logic        eoc, eos, busy;

    logic        model_done = 1'b0;
    logic        stray_done = 1'b0;
    assign conv_done = model_done | stray_done;

    int checks = 0;
    int fails  = 0;
    int lat    = 0;
    bit pend   = 0;
    int dly    = 0;

    int start_log [64];
    int n_start = 0;
    int n_eoc   = 0;
    int n_eos   = 0;
    int eos_at  = -1;
    bit wd_hit  = 0;

    always #4 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trigger(trigger),
        .disc_en(disc_en), .disc_size(disc_size), .seq_len(seq_len),
        .seq_chans(seq_chans), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .eoc(eoc), .eos(eos), .busy(busy)
    );

    function automatic int chan_of(int i);
        return (i * 7 + 3) % 32;
    endfunction

    // Converter model: answers each request after 'lat' extra cycles.
    always @(negedge clk) begin
        model_done = 1'b0;
        if (pend) begin
            if (dly == 0) begin model_done = 1'b1; pend = 0; end
            else dly--;
        end else if (conv_start) begin
            pend = 1; dly = lat;
        end
    end

    // Monitor: logs requests and event pulses.
    always @(negedge clk) begin
        if (conv_start && n_start < 64) begin
            start_log[n_start] = conv_chan;
            n_start++;
        end
        if (eoc) n_eoc++;
        if (eos) begin n_eos++; eos_at = n_eoc; end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_start = 0; n_eoc = 0; n_eos = 0; eos_at = -1;
    endtask

    task automatic pulse_trigger();
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
    endtask

    // Check that the logged requests equal entries first..first+cnt-1.
    task automatic expect_run(string req, int first, int cnt, int eos_pos);
        chk(n_start == cnt, req, n_start, cnt);
        chk(n_eoc == cnt, "R7", n_eoc, cnt);
        for (int k = 0; k < cnt && k < n_start; k++)
            chk(start_log[k] == chan_of(first + k), req, start_log[k], chan_of(first + k));
        if (eos_pos < 0) chk(n_eos == 0, "R8", n_eos, 0);
        else begin
            chk(n_eos == 1, "R8", n_eos, 1);
            chk(eos_at == eos_pos, "R8", eos_at, eos_pos);
        end
    endtask

    task automatic run_group(string req, int first, int cnt, int eos_pos);
        clear_log();
        pulse_trigger();
        wait_idle();
        expect_run(req, first, cnt, eos_pos);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!conv_start && !eoc && !eos && !busy, "R1", busy, 0);
    endtask

    task automatic t_continuous();
        disc_en = 0; seq_len = 4'd8; lat = 1;
        run_group("R2", 0, 9, 9);
        run_group("R3", 0, 9, 9);
    endtask

    task automatic t_disc_even();
        disc_en = 1; disc_size = 3'd2; seq_len = 4'd8; lat = 0;
        run_group("R4", 0, 3, -1);
        run_group("R4", 3, 3, -1);
        run_group("R6", 6, 3, 3);
        run_group("R5", 0, 3, -1);
    endtask

    task automatic t_disc_short();
        enable = 0; @(negedge clk); enable = 1;
        disc_en = 1; disc_size = 3'd3; seq_len = 4'd9; lat = 2;
        run_group("R4", 0, 4, -1);
        run_group("R4", 4, 4, -1);
        run_group("R6", 8, 2, 2);
        run_group("R5", 0, 4, -1);
    endtask

    task automatic t_busy_ignore();
        enable = 0; @(negedge clk); enable = 1;
        disc_en = 0; seq_len = 4'd3; lat = 3;
        clear_log();
        pulse_trigger();
        repeat (4) @(negedge clk);
        chk(busy, "R9", busy, 1);
        trigger = 1'b1; @(negedge clk); trigger = 1'b0;
        wait_idle();
        expect_run("R9", 0, 4, 4);
        clear_log();
        stray_done = 1'b1; @(negedge clk); stray_done = 1'b0;
        repeat (3) @(negedge clk);
        chk(n_eoc == 0, "R10", n_eoc, 0);
        chk(n_start == 0 && !busy, "R10", n_start, 0);
    endtask

    task automatic t_abort();
        enable = 0; @(negedge clk); enable = 1;
        disc_en = 1; disc_size = 3'd1; seq_len = 4'd7; lat = 4;
        run_group("R11", 0, 2, -1);
        clear_log();
        pulse_trigger();
        repeat (2) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!busy, "R11", busy, 0);
        repeat (8) @(negedge clk);
        chk(n_eoc == 0, "R11", n_eoc, 0);
        enable = 1'b1;
        run_group("R11", 0, 2, -1);
    endtask

    task automatic t_full_len();
        enable = 0; @(negedge clk); enable = 1;
        disc_en = 0; seq_len = 4'd15; lat = 0;
        run_group("R12", 0, 16, 16);
        disc_en = 1; disc_size = 3'd7;
        run_group("R12", 0, 8, -1);
        run_group("R12", 8, 8, 8);
        disc_en = 0; seq_len = 4'd0;
        run_group("R12", 0, 1, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) seq_chans[i*5 +: 5] = 5'(chan_of(i));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1; enable = 1'b1;
        @(negedge clk);
        t_reset();
        t_continuous();
        t_disc_even();
        t_disc_short();
        t_busy_ignore();
        t_abort();
        t_full_len();
        if (wd_hit) begin fails++; checks++; end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        wd_hit = 1;
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule